// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block is the timekeeping core of a real-time clock. It holds seven packed-BCD fields: seconds, minutes, hours, date, month, day of week and year. An internal divider turns the system clock into one advance per second. Each advance steps the seconds field and ripples carries through the calendar. The carries respect month lengths, leap years and the selected hour format.

A serial front end sits next to it. That front end loads all seven fields at once through a 56-bit parallel port. It reads them back either live or from a holding copy. The holding copy is captured in a single cycle, so a multi-byte read never sees a carry that is only partly done.

The hours field has two encodings, 24-hour and 12-hour, selected by its top bit. The seconds field carries a halt bit that freezes the calendar.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the live and held values are seconds 00, minutes 00, hours 00 in 24-hour mode, date 01, month 01, day of week 1, year 00, with halt clear.
- R2: The 56-bit bus packs seconds in bits 7:0, minutes in 15:8, hours in 23:16, date in 31:24, month in 39:32, day of week in 47:40 and year in 55:48. Seconds and minutes count 00 to 59 in BCD, and 59 wraps to 00 with a carry into the next field.
- R3: Bit 7 of the seconds byte is a halt flag. While it is 1 no field advances. Loading it as 0 lets counting resume.
- R4: When hours bit 7 is 0 (24-hour mode), hours bits 5:0 hold BCD 00 to 23, and bit 5 acts as the tens-of-twenty bit.
- R5: When hours bit 7 is 1 (12-hour mode), bit 5 is the PM flag (1 = PM) and bits 4:0 hold BCD 12, 01 … 11. The step from 11 to 12 inverts the PM flag, and the step from 12 goes to 01.
- R6: A day carry occurs on 23→00 in 24-hour mode, or on 11 PM→12 AM in 12-hour mode. It increments the date and steps the day of week 1…7, with 7 wrapping to 1.
- R7: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other non-February months. Month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R8: February ends after 29 when the BCD year is divisible by 4 (including 00), and after 28 otherwise.
- R9: The time advances once every TICKS_PER_SEC clocks. A load takes effect on the next clock edge, has priority over an advance in the same cycle, and restarts the divider, so the next advance comes TICKS_PER_SEC edges after the load edge.
- R10: A capture pulse copies all seven live fields into the held set on the next edge. The held set does not change without a capture.
- R11: Loads clear unused bits: minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5 and day-of-week bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load all fields from load_time on this edge |
| load_time | input | 56 | Packed BCD fields to load |
| snap_cap | input | 1 | Capture the live fields into the held set |
| live_time | output | 56 | Current packed BCD fields |
| snap_time | output | 56 | Held copy from the last capture |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4. This makes each one-second advance four clocks long, so every carry chain is reached within a few cycles of a load placed one second before a boundary. Examples are the February end in leap and common years, the year 99 wrap and the 11 PM step in 12-hour mode. The short period also makes it cheap to show the divider restart: a second load is placed one clock before the advance would have fallen due.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int TIME_W = 56;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] dow;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam rtc_time_t RTC_RESET = '{
        year:  8'h00,
        dow:   8'h01,
        month: 8'h01,
        date:  8'h01,
        hour:  8'h00,
        min:   8'h00,
        sec:   8'h00
    };

    // One BCD step; digit carry from units into tens.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'h0};
        else
            return v + 8'd1;
    endfunction

    // 10 is 2 mod 4, so tens*2 + units decides divisibility by 4.
    function automatic logic leap_year(input logic [7:0] y);
        logic [5:0] s;
        s = {1'b0, y[7:4], 1'b0} + {2'b00, y[3:0]};
        return (s & 6'h03) == 6'h00;
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t mask_fields(input rtc_time_t t);
        rtc_time_t r;
        r = t;
        r.min[7]     = 1'b0;
        r.hour[6]    = 1'b0;
        r.date[7:6]  = 2'b00;
        r.month[7:5] = 3'b000;
        r.dow[7:3]   = 5'b00000;
        return r;
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R9: a load restarts the sub-second count
    assert_div_restart_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    // R9: advances never come on back-to-back clocks
    assert_tick_gap_R9: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    logic       sec_wrap, min_wrap, hour_step, day_step;
    logic       date_wrap, mon_step, mon_wrap, yr_step;
    logic [7:0] sec_inc, min_inc, hr_inc, date_inc, mon_inc, yr_inc, last_day;
    logic [4:0] h12;
    logic       pm;

    always_comb begin
        nxt = cur;

        // seconds, halt bit passes through
        sec_inc  = bcd_inc({1'b0, cur.sec[6:0]});
        sec_wrap = (cur.sec[6:0] == 7'h59);
        nxt.sec  = {cur.sec[7], 7'h00} | (sec_wrap ? 8'h00 : (sec_inc & 8'h7F));

        // minutes
        min_inc  = bcd_inc(cur.min);
        min_wrap = (cur.min == 8'h59);
        if (sec_wrap)
            nxt.min = min_wrap ? 8'h00 : min_inc;

        // hours, two encodings
        hour_step = sec_wrap & min_wrap;
        day_step  = 1'b0;
        h12       = cur.hour[4:0];
        pm        = cur.hour[5];
        hr_inc    = 8'h00;
        if (hour_step) begin
            if (cur.hour[7]) begin
                hr_inc = bcd_inc({3'b000, h12});
                if (h12 == 5'h11) begin
                    nxt.hour = {3'b101, 5'h12} ^ {2'b00, pm, 5'h00};
                    day_step = pm;
                end else if (h12 == 5'h12) begin
                    nxt.hour = 8'h81 | {2'b00, pm, 5'h00};
                end else begin
                    nxt.hour = 8'h80 | {2'b00, pm, 5'h00} | (hr_inc & 8'h1F);
                end
            end else begin
                hr_inc = bcd_inc({2'b00, cur.hour[5:0]});
                if (cur.hour[5:0] == 6'h23) begin
                    nxt.hour = 8'h00;
                    day_step = 1'b1;
                end else begin
                    nxt.hour = hr_inc & 8'h3F;
                end
            end
        end

        // date and day of week
        last_day  = month_last(cur.month, cur.year);
        date_inc  = bcd_inc(cur.date);
        date_wrap = (cur.date == last_day);
        if (day_step) begin
            nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : cur.dow + 8'd1;
            nxt.date = date_wrap ? 8'h01 : date_inc;
        end

        // month and year
        mon_step = day_step & date_wrap;
        mon_wrap = (cur.month == 8'h12);
        mon_inc  = bcd_inc(cur.month);
        if (mon_step)
            nxt.month = mon_wrap ? 8'h01 : mon_inc;

        yr_step = mon_step & mon_wrap;
        yr_inc  = bcd_inc(cur.year);
        if (yr_step)
            nxt.year = (cur.year == 8'h99) ? 8'h00 : yr_inc;
    end

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cap,
    input  rtc_time_t live,
    output rtc_time_t held
);
    always_ff @(posedge clk) begin
        if (rst)
            held <= RTC_RESET;
        else if (cap)
            held <= live;
    end

    // R10: the held set only moves on a capture
    assert_snap_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(held));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [TIME_W-1:0] load_time,
    input  logic              snap_cap,
    output logic [TIME_W-1:0] live_time,
    output logic [TIME_W-1:0] snap_time
);
    rtc_time_t now_t, next_t, held_t;
    logic      tick;
    logic      halted;

    rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (load_en),
        .tick    (tick)
    );

    rtc_advance u_adv (
        .cur (now_t),
        .nxt (next_t)
    );

    assign halted = now_t.sec[7];

    always_ff @(posedge clk) begin
        if (rst)
            now_t <= RTC_RESET;
        else if (load_en)
            now_t <= mask_fields(rtc_time_t'(load_time));
        else if (tick && !halted)
            now_t <= next_t;
    end

    rtc_snapshot u_snap (
        .clk  (clk),
        .rst  (rst),
        .cap  (snap_cap),
        .live (now_t),
        .held (held_t)
    );

    assign live_time = now_t;
    assign snap_time = held_t;

    // R3: nothing moves while halted unless loaded
    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_en && halted) |=> $stable(now_t));

    // R2: seconds wrap to zero after 59
    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && !halted && now_t.sec[6:0] == 7'h59) |=> (now_t.sec[6:0] == 7'h00));

    // R5: 11 -> 12 step in 12-hour mode inverts the PM flag
    assert_pm_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && !halted && now_t.hour[7] && now_t.hour[4:0] == 5'h11 &&
         now_t.min == 8'h59 && now_t.sec[6:0] == 7'h59)
        |=> (now_t.hour[5] != $past(now_t.hour[5])));

    // R11: unused bits are cleared by a load
    assert_load_mask_R11: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (now_t.min[7] == 1'b0 && now_t.hour[6] == 1'b0 &&
                     now_t.date[7:6] == 2'b00 && now_t.month[7:5] == 3'b000 &&
                     now_t.dow[7:3] == 5'b00000));

endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [55:0] load_time = '0;
    logic        snap_cap = 1'b0;
    logic [55:0] live_time, snap_time;

    always #4 clk = ~clk;

    rtc_calendar_core #(.TICKS_PER_SEC(DIV)) u_dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_time(load_time),
        .snap_cap(snap_cap), .live_time(live_time), .snap_time(snap_time)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [55:0] exp;
        bit          snap;
        string       tag;
    } item_t;
    item_t q[$];

    // reference model in plain integers, hours kept 0..23
    int m_sec, m_min, m_hr, m_date, m_mon, m_dow, m_yr;
    bit m_halt, m_12;

    function automatic logic [7:0] bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int unbcd(logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [55:0] pk(logic [7:0] y, logic [7:0] w, logic [7:0] mo,
                                       logic [7:0] d, logic [7:0] h, logic [7:0] mi,
                                       logic [7:0] s);
        return {y, w, mo, d, h, mi, s};
    endfunction

    function automatic logic [55:0] enc();
        logic [7:0] s, h, hb;
        int hh;
        s = bcd(m_sec);
        s[7] = m_halt;
        if (m_12) begin
            hh = m_hr % 12;
            if (hh == 0) hh = 12;
            hb = bcd(hh);
            h = {1'b1, 1'b0, (m_hr >= 12), hb[4:0]};
        end else begin
            h = bcd(m_hr);
        end
        return {bcd(m_yr), bcd(m_dow), bcd(m_mon), bcd(m_date), h, bcd(m_min), s};
    endfunction

    function automatic void decode(logic [55:0] raw);
        int h;
        m_halt = raw[7];
        m_sec  = unbcd({1'b0, raw[6:0]});
        m_min  = unbcd({1'b0, raw[14:8]});
        m_12   = raw[23];
        if (m_12) begin
            h    = unbcd({3'b000, raw[20:16]});
            m_hr = (h % 12) + (raw[21] ? 12 : 0);
        end else begin
            m_hr = unbcd({2'b00, raw[21:16]});
        end
        m_date = unbcd({2'b00, raw[29:24]});
        m_mon  = unbcd({3'b000, raw[36:32]});
        m_dow  = int'(raw[42:40]);
        m_yr   = unbcd(raw[55:48]);
    endfunction

    function automatic int dim(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic void adv();
        if (m_halt) return;
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr++;
        if (m_hr < 24) return;
        m_hr = 0;
        m_dow = (m_dow % 7) + 1;
        m_date++;
        if (m_date <= dim(m_mon, m_yr)) return;
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1;
        m_yr = (m_yr + 1) % 100;
    endfunction

    task automatic push(logic [55:0] e, bit s, string tag);
        item_t it;
        it.exp = e; it.snap = s; it.tag = tag;
        q.push_back(it);
    endtask

    // driver tasks start and end just after a falling edge
    task automatic load(logic [55:0] raw, string tag);
        load_time = raw;
        load_en   = 1'b1;
        @(negedge clk);
        load_en   = 1'b0;
        decode(raw);
        push(enc(), 0, tag);
    endtask

    task automatic run_ticks(int n, string tag);
        for (int k = 0; k < n; k++) begin
            repeat (DIV) @(negedge clk);
            adv();
            push(enc(), 0, tag);
        end
    endtask

    // monitor: compares every queued expectation shortly after the falling edge
    always begin
        @(negedge clk);
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [55:0] act;
            it  = q.pop_front();
            act = it.snap ? snap_time : live_time;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [55:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        push(pk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), 0, "R1 live after reset");
        push(pk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), 1, "R1 held after reset");

        // R2 R4 R6 R8: common-year February end, 24-hour day carry, dow 7->1
        load(pk(8'h23, 8'h07, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58), "R2 load");
        run_ticks(2, "R2 R6 R8 common-year Feb 28 rollover");
        run_ticks(1, "R2 seconds step");

        // R4 plain hour step in 24-hour mode (19 -> 20 uses bit 5)
        load(pk(8'h10, 8'h02, 8'h05, 8'h10, 8'h19, 8'h59, 8'h59), "R4 load");
        run_ticks(1, "R4 hour 19 to 20");

        // R8 leap year
        load(pk(8'h24, 8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59), "R8 load");
        run_ticks(1, "R8 leap Feb 28 to 29");
        load(pk(8'h24, 8'h04, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59), "R8 load");
        run_ticks(1, "R8 leap Feb 29 to Mar 1");
        load(pk(8'h00, 8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59), "R8 load");
        run_ticks(1, "R8 year 00 is leap");

        // R7 month lengths and year wrap
        load(pk(8'h23, 8'h01, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59), "R7 load");
        run_ticks(1, "R7 April 30 rollover");
        load(pk(8'h23, 8'h01, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59), "R7 load");
        run_ticks(1, "R7 January 30 to 31");
        load(pk(8'h99, 8'h06, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59), "R7 load");
        run_ticks(1, "R7 year 99 wrap");

        // R5 12-hour encodings
        load(pk(8'h21, 8'h02, 8'h06, 8'h15, 8'h91, 8'h59, 8'h59), "R5 load");
        run_ticks(1, "R5 11 AM to 12 PM");
        load(pk(8'h21, 8'h02, 8'h06, 8'h15, 8'hB2, 8'h59, 8'h59), "R5 load");
        run_ticks(1, "R5 12 PM to 1 PM");
        load(pk(8'h21, 8'h02, 8'h06, 8'h15, 8'hB1, 8'h59, 8'h59), "R5 load");
        run_ticks(1, "R5 R6 11 PM to 12 AM day carry");
        run_ticks(1, "R5 stays 12 AM");

        // R3 halt
        load(pk(8'h22, 8'h03, 8'h07, 8'h04, 8'h08, 8'h30, 8'hA0), "R3 halted load");
        run_ticks(3, "R3 halted no advance");
        load(pk(8'h22, 8'h03, 8'h07, 8'h04, 8'h08, 8'h30, 8'h20), "R3 resume load");
        run_ticks(2, "R3 resumed counting");

        // R9 divider restart on load
        load(pk(8'h22, 8'h03, 8'h07, 8'h04, 8'h08, 8'h30, 8'h00), "R9 first load");
        repeat (2) @(negedge clk);
        load(pk(8'h22, 8'h03, 8'h07, 8'h04, 8'h08, 8'h30, 8'h00), "R9 second load");
        repeat (DIV - 1) @(negedge clk);
        push(enc(), 0, "R9 no advance before a full period");
        @(negedge clk);
        adv();
        push(enc(), 0, "R9 advance one period after load");

        // R10 snapshot holds while live moves
        load(pk(8'h15, 8'h05, 8'h08, 8'h20, 8'h12, 8'h34, 8'h56), "R10 load");
        held = enc();
        snap_cap = 1'b1;
        @(negedge clk);
        snap_cap = 1'b0;
        push(held, 1, "R10 capture");
        repeat (DIV - 1) @(negedge clk);
        adv();
        push(enc(), 0, "R10 live moved");
        push(held, 1, "R10 held unchanged");
        run_ticks(1, "R10 live moves again");
        push(held, 1, "R10 held still unchanged");

        // R11 masking of unused bits
        load(pk(8'h07, 8'hFA, 8'hE3, 8'hC5, 8'h52, 8'h85, 8'h10), "R11 masked load");
        run_ticks(1, "R11 count after masked load");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule